// File: doc/BRIEF.md
# Subscription-Based Wakeup Issue Queue

This block holds renamed instructions of a small out-of-order core until their operands are available, then hands them one at a time to execution. It does not compare result tags against every waiting entry. Instead, each newly dispatched instruction writes its own queue index into one of a few subscriber slots owned by each producer it depends on. When that producer issues, its slots name exactly which entries and which source bits to mark ready.

Each instruction names up to two producers by their queue index. A producer that is absent from the queue, or is issuing in the same cycle, needs no subscription. If a producer has no free slot left, or the queue has no free entry, dispatch is refused for that cycle. Selection is positional rather than age-ordered: the lowest-numbered ready entry wins. The execution side gates selection with an allow input. A flush empties the whole queue in one cycle.

Top module: `subq_issue_queue`

## Requirements
- R1: After reset the queue is empty: `full` is low, `iss_valid` is low, `disp_ready` is high and `disp_idx` is 0.
- R2: A dispatch is accepted in a cycle where `disp_valid` and `disp_ready` are high and `flush` is low. It is written into the lowest-numbered free entry, and that index is shown on `disp_idx` in the same cycle.
- R3: A source is ready from dispatch when any of these holds: its valid bit is low, the entry it names is empty, or the entry it names is issuing in the same cycle. An entry with all sources ready can issue in the next cycle.
- R4: A source whose producer is present and not issuing waits. The consumer cannot be selected before its producer issues, and it becomes eligible in the cycle right after the producer's issue cycle.
- R5: When a producer issues, every consumer recorded in its slots has the recorded source marked ready.
- R6: Each entry owns 2 subscriber slots. When a source needs a slot and its producer has none free, `disp_ready` is low and the dispatch is dropped, which leaves the free entry unallocated.
- R7: When both sources name the same waiting producer, they use two of its slots. Dispatch stalls if fewer than two are free, and both source bits are woken by the single issue of that producer.
- R8: When `iss_allow` is high, the lowest-numbered ready entry is shown on `iss_valid`/`iss_idx`/`iss_payload`, regardless of age. When `iss_allow` is low, `iss_valid` is low.
- R9: At most one entry issues per cycle. The issued entry is free from the next clock edge, and its slots are cleared.
- R10: When all 16 entries are occupied, `full` is high and `disp_ready` is low.
- R11: `flush` clears every entry, ready bit and subscriber slot at the next edge. A dispatch or issue offered in the flush cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empties the queue at the next edge |
| disp_valid | input | 1 | Dispatch request |
| disp_src0_vld | input | 1 | First source depends on a queue entry |
| disp_src0_idx | input | 4 | Queue index of first source's producer |
| disp_src1_vld | input | 1 | Second source depends on a queue entry |
| disp_src1_idx | input | 4 | Queue index of second source's producer |
| disp_payload | input | 8 | Opaque instruction data stored with the entry |
| disp_ready | output | 1 | Dispatch can be accepted this cycle |
| disp_idx | output | 4 | Entry the dispatch is written into |
| full | output | 1 | No free entry |
| iss_allow | input | 1 | Execution side can take an instruction this cycle |
| iss_valid | output | 1 | An entry issues this cycle |
| iss_idx | output | 4 | Index of the issuing entry |
| iss_payload | output | 8 | Payload of the issuing entry |

## Verification
The hardest situation to reach is a producer that stays in the queue while consumers subscribe to it. Without back-pressure every ready root leaves one cycle after dispatch, so slots never fill. The bench holds `iss_allow` low to build up producers and to exhaust their slots. It then releases selection for a single cycle to punch a hole at a low index, so that a consumer can sit below its producer. That placement shows that the wait comes from the pointer-directed wakeup and not from positional priority.

// File: rtl/subq_pkg.sv
`timescale 1ns/1ps
package subq_pkg;
   localparam int NUM_SRC = 2;
   typedef enum logic {SRC_A = 1'b0, SRC_B = 1'b1} src_sel_e;
endpackage

// File: rtl/subq_prio_enc.sv
`timescale 1ns/1ps
// Fixed priority encoder: lowest set request bit wins.
module subq_prio_enc #(
   parameter int W = 16,
   localparam int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);
   if (W < 2) begin : g_bad_width
      $error("subq_prio_enc: W must be at least 2");
   end

   always_comb begin
      any = |req;
      idx = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/subq_slot_pick.sv
`timescale 1ns/1ps
// Picks a free subscriber slot of one producer, skipping slots claimed
// earlier in the same dispatch.
module subq_slot_pick #(
   parameter int SLOTS = 2,
   localparam int SW = $clog2(SLOTS)
) (
   input  logic [SLOTS-1:0] busy,
   input  logic [SLOTS-1:0] taken,
   output logic             ok,
   output logic [SW-1:0]    pick,
   output logic [SLOTS-1:0] pick_oh
);
   subq_prio_enc #(.W(SLOTS)) u_enc (
      .req (~busy & ~taken),
      .any (ok),
      .idx (pick)
   );

   assign pick_oh = ok ? (SLOTS'(1) << pick) : '0;
endmodule

// File: rtl/subq_issue_queue.sv
`timescale 1ns/1ps
module subq_issue_queue
   import subq_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int SLOTS   = 2,
   parameter int PAY_W   = 8,
   localparam int IW = $clog2(ENTRIES),
   localparam int SW = $clog2(SLOTS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             disp_valid,
   input  logic             disp_src0_vld,
   input  logic [IW-1:0]    disp_src0_idx,
   input  logic             disp_src1_vld,
   input  logic [IW-1:0]    disp_src1_idx,
   input  logic [PAY_W-1:0] disp_payload,
   output logic             disp_ready,
   output logic [IW-1:0]    disp_idx,
   output logic             full,
   input  logic             iss_allow,
   output logic             iss_valid,
   output logic [IW-1:0]    iss_idx,
   output logic [PAY_W-1:0] iss_payload
);
   if (ENTRIES < 2 || (1 << IW) != ENTRIES) begin : g_bad_entries
      $error("subq_issue_queue: ENTRIES must be a power of two >= 2");
   end
   if (SLOTS < 2 || (1 << SW) != SLOTS) begin : g_bad_slots
      $error("subq_issue_queue: SLOTS must be a power of two >= 2");
   end
   if (NUM_SRC != 2) begin : g_bad_src
      $error("subq_issue_queue: exactly two sources are supported");
   end

   // ---------------- state ----------------
   logic [ENTRIES-1:0]   valid_q;
   logic [NUM_SRC-1:0]   rdy_q  [ENTRIES];
   logic [PAY_W-1:0]     pay_q  [ENTRIES];
   logic [SLOTS-1:0]     sv_q   [ENTRIES];
   logic [IW-1:0]        sidx_q [ENTRIES][SLOTS];
   src_sel_e             ssrc_q [ENTRIES][SLOTS];

   // ---------------- select ----------------
   logic [ENTRIES-1:0] eligible;
   for (genvar e = 0; e < ENTRIES; e++) begin : g_elig
      assign eligible[e] = valid_q[e] & (&rdy_q[e]) & iss_allow;
   end

   subq_prio_enc #(.W(ENTRIES)) u_select (
      .req (eligible),
      .any (iss_valid),
      .idx (iss_idx)
   );
   assign iss_payload = pay_q[iss_idx];

   // ---------------- allocation ----------------
   logic          have_free;
   logic [IW-1:0] alloc_idx;

   subq_prio_enc #(.W(ENTRIES)) u_alloc (
      .req (~valid_q),
      .any (have_free),
      .idx (alloc_idx)
   );
   assign full     = ~have_free;
   assign disp_idx = alloc_idx;

   // ---------------- subscription ----------------
   logic             need0, need1, ok0, ok1;
   logic [SW-1:0]    pick0, pick1;
   logic [SLOTS-1:0] oh0, oh1, taken1;

   assign need0 = disp_src0_vld & valid_q[disp_src0_idx]
                & ~(iss_valid && iss_idx == disp_src0_idx);
   assign need1 = disp_src1_vld & valid_q[disp_src1_idx]
                & ~(iss_valid && iss_idx == disp_src1_idx);
   assign taken1 = (need0 && disp_src0_idx == disp_src1_idx) ? oh0 : '0;

   subq_slot_pick #(.SLOTS(SLOTS)) u_pick0 (
      .busy    (sv_q[disp_src0_idx]),
      .taken   ('0),
      .ok      (ok0),
      .pick    (pick0),
      .pick_oh (oh0)
   );
   subq_slot_pick #(.SLOTS(SLOTS)) u_pick1 (
      .busy    (sv_q[disp_src1_idx]),
      .taken   (taken1),
      .ok      (ok1),
      .pick    (pick1),
      .pick_oh (oh1)
   );

   logic disp_fire;
   assign disp_ready = have_free & (~need0 | ok0) & (~need1 | ok1);
   assign disp_fire  = disp_valid & disp_ready & ~flush;

   // ---------------- control state ----------------
   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         valid_q <= '0;
         for (int e = 0; e < ENTRIES; e++) begin
            rdy_q[e] <= '0;
            sv_q[e]  <= '0;
         end
      end else begin
         if (iss_valid) begin
            valid_q[iss_idx] <= 1'b0;
            sv_q[iss_idx]    <= '0;
            for (int s = 0; s < SLOTS; s++) begin
               if (sv_q[iss_idx][s])
                  rdy_q[sidx_q[iss_idx][s]][ssrc_q[iss_idx][s]] <= 1'b1;
            end
         end
         if (disp_fire) begin
            valid_q[alloc_idx]       <= 1'b1;
            rdy_q[alloc_idx][SRC_A]  <= ~need0;
            rdy_q[alloc_idx][SRC_B]  <= ~need1;
            if (need0) sv_q[disp_src0_idx][pick0] <= 1'b1;
            if (need1) sv_q[disp_src1_idx][pick1] <= 1'b1;
         end
      end
   end

   // ---------------- data state (no reset needed) ----------------
   always_ff @(posedge clk) begin
      if (disp_fire) begin
         pay_q[alloc_idx] <= disp_payload;
         if (need0) begin
            sidx_q[disp_src0_idx][pick0] <= alloc_idx;
            ssrc_q[disp_src0_idx][pick0] <= SRC_A;
         end
         if (need1) begin
            sidx_q[disp_src1_idx][pick1] <= alloc_idx;
            ssrc_q[disp_src1_idx][pick1] <= SRC_B;
         end
      end
   end

   // ---------------- assertions ----------------
   p_flush_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (valid_q == '0));

   p_issue_frees_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && !flush) |=> !valid_q[$past(iss_idx)]);

   p_alloc_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
      disp_fire |=> (valid_q[$past(alloc_idx)]
                     && pay_q[$past(alloc_idx)] == $past(disp_payload)));

   for (genvar s = 0; s < SLOTS; s++) begin : g_wake_chk
      p_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (iss_valid && !flush && sv_q[iss_idx][s])
            |=> rdy_q[$past(sidx_q[iss_idx][s])][$past(ssrc_q[iss_idx][s])]);
   end

   for (genvar e = 0; e < ENTRIES; e++) begin : g_live_chk
      for (genvar s = 0; s < SLOTS; s++) begin : g_slot
         p_sub_waiting_r4: assert property (@(posedge clk) disable iff (!rst_n)
            sv_q[e][s] |-> (valid_q[e] && valid_q[sidx_q[e][s]]
                            && !rdy_q[sidx_q[e][s]][ssrc_q[e][s]]));
      end
   end
endmodule

// File: tb/subq_issue_queue_bench.sv
`timescale 1ns/1ps
module subq_issue_queue_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       flush = 1'b0;
   logic       disp_valid = 1'b0;
   logic       disp_src0_vld = 1'b0;
   logic [3:0] disp_src0_idx = '0;
   logic       disp_src1_vld = 1'b0;
   logic [3:0] disp_src1_idx = '0;
   logic [7:0] disp_payload = '0;
   logic       disp_ready;
   logic [3:0] disp_idx;
   logic       full;
   logic       iss_allow = 1'b0;
   logic       iss_valid;
   logic [3:0] iss_idx;
   logic [7:0] iss_payload;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   subq_issue_queue u_subq_issue_queue (
      .clk, .rst_n, .flush, .disp_valid,
      .disp_src0_vld, .disp_src0_idx, .disp_src1_vld, .disp_src1_idx,
      .disp_payload, .disp_ready, .disp_idx, .full, .iss_allow,
      .iss_valid, .iss_idx, .iss_payload
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic drive(input bit v, input bit s0v, input int p0,
                        input bit s1v, input int p1, input int pay);
      disp_valid    = v;
      disp_src0_vld = s0v;
      disp_src0_idx = 4'(p0);
      disp_src1_vld = s1v;
      disp_src1_idx = 4'(p1);
      disp_payload  = 8'(pay);
   endtask

   task automatic idle();
      drive(0, 0, 0, 0, 0, 0);
   endtask

   task automatic expect_issue(input string req, input int idx, input int pay);
      chk({req, " iss_valid"}, iss_valid, 1);
      chk({req, " iss_idx"}, iss_idx, idx);
      chk({req, " iss_payload"}, iss_payload, pay);
   endtask

   // R1
   task automatic t_reset();
      #1;
      chk("R1 full", full, 0);
      chk("R1 iss_valid", iss_valid, 0);
      chk("R1 disp_ready", disp_ready, 1);
      chk("R1 disp_idx", disp_idx, 0);
   endtask

   // R2, R3, R9: roots with absent and issuing producers
   task automatic t_ready_at_dispatch();
      iss_allow = 1;
      drive(1, 1, 5, 0, 0, 8'h11);
      #1;
      chk("R2 disp_ready", disp_ready, 1);
      chk("R2 disp_idx", disp_idx, 0);
      tick();
      drive(1, 1, 0, 0, 0, 8'h22);
      #1;
      expect_issue("R3 absent producer", 0, 8'h11);
      chk("R3 consumer of issuing producer accepted", disp_ready, 1);
      chk("R2 next free index", disp_idx, 1);
      tick();
      idle();
      #1;
      expect_issue("R3 issuing producer", 1, 8'h22);
      tick();
      #1;
      chk("R9 queue drained", iss_valid, 0);
      chk("R9 entry freed", disp_idx, 0);
   endtask

   // R4, R8: consumer placed below its producer must still wait
   task automatic t_consumer_below();
      iss_allow = 0;
      drive(1, 0, 0, 0, 0, 8'hA0);
      tick();
      drive(1, 0, 0, 0, 0, 8'hA1);
      tick();
      idle();
      #1;
      chk("R8 allow low blocks issue", iss_valid, 0);
      iss_allow = 1;
      #1;
      expect_issue("R8 lowest first", 0, 8'hA0);
      tick();
      iss_allow = 0;
      drive(1, 1, 1, 0, 0, 8'hC0);
      #1;
      chk("R2 hole reused", disp_idx, 0);
      chk("R4 subscribe accepted", disp_ready, 1);
      tick();
      idle();
      iss_allow = 1;
      #1;
      expect_issue("R4 waiting consumer skipped", 1, 8'hA1);
      tick();
      #1;
      expect_issue("R4 woken next cycle", 0, 8'hC0);
      tick();
      #1;
      chk("R4 drained", iss_valid, 0);
   endtask

   // R5, R6: two subscribers, third stalls
   task automatic t_fanout();
      iss_allow = 0;
      drive(1, 0, 0, 0, 0, 8'h30);
      tick();
      drive(1, 1, 0, 0, 0, 8'h31);
      tick();
      drive(1, 0, 0, 1, 0, 8'h32);
      tick();
      drive(1, 1, 0, 0, 0, 8'h33);
      #1;
      chk("R6 no free slot stalls", disp_ready, 0);
      tick();
      idle();
      #1;
      chk("R6 stalled dispatch dropped", disp_idx, 3);
      iss_allow = 1;
      #1;
      expect_issue("R5 producer", 0, 8'h30);
      tick();
      #1;
      expect_issue("R5 first subscriber", 1, 8'h31);
      tick();
      #1;
      expect_issue("R5 second subscriber", 2, 8'h32);
      tick();
      #1;
      chk("R6 dropped entry never issues", iss_valid, 0);
   endtask

   // R7: both sources on one producer
   task automatic t_same_producer();
      iss_allow = 0;
      drive(1, 0, 0, 0, 0, 8'h40);
      tick();
      drive(1, 1, 0, 1, 0, 8'h41);
      #1;
      chk("R7 two slots available", disp_ready, 1);
      tick();
      drive(1, 1, 0, 0, 0, 8'h42);
      #1;
      chk("R7 both slots consumed", disp_ready, 0);
      tick();
      idle();
      iss_allow = 1;
      #1;
      expect_issue("R7 producer", 0, 8'h40);
      tick();
      #1;
      expect_issue("R7 both sources woken", 1, 8'h41);
      tick();
      #1;
      chk("R7 drained", iss_valid, 0);
   endtask

   // R8, R2: positional priority beats age
   task automatic t_priority();
      iss_allow = 0;
      for (int i = 0; i < 3; i++) begin
         drive(1, 0, 0, 0, 0, 8'h50 + i);
         tick();
      end
      idle();
      iss_allow = 1;
      #1;
      expect_issue("R8 first pass", 0, 8'h50);
      tick();
      iss_allow = 0;
      drive(1, 0, 0, 0, 0, 8'h53);
      #1;
      chk("R2 lowest free", disp_idx, 0);
      tick();
      idle();
      iss_allow = 1;
      #1;
      expect_issue("R8 youngest at index 0 first", 0, 8'h53);
      tick();
      #1;
      expect_issue("R8 then index 1", 1, 8'h51);
      tick();
      #1;
      expect_issue("R8 then index 2", 2, 8'h52);
      tick();
      #1;
      chk("R9 one per cycle drained", iss_valid, 0);
   endtask

   // R10, R11: fill, flush, and reuse slots
   task automatic t_full_flush();
      iss_allow = 0;
      for (int i = 0; i < 16; i++) begin
         if (i == 1 || i == 2) drive(1, 1, 0, 0, 0, 8'h60 + i);
         else drive(1, 0, 0, 0, 0, 8'h60 + i);
         #1;
         chk("R10 fill index", disp_idx, i);
         tick();
      end
      idle();
      #1;
      chk("R10 full", full, 1);
      chk("R10 disp_ready low", disp_ready, 0);
      flush = 1;
      iss_allow = 1;
      #1;
      tick();
      flush = 0;
      iss_allow = 0;
      #1;
      chk("R11 not full", full, 0);
      chk("R11 index 0 free", disp_idx, 0);
      iss_allow = 1;
      #1;
      chk("R11 nothing left", iss_valid, 0);
      iss_allow = 0;
      drive(1, 0, 0, 0, 0, 8'h70);
      tick();
      drive(1, 1, 0, 0, 0, 8'h71);
      #1;
      chk("R11 slot 0 cleared", disp_ready, 1);
      tick();
      drive(1, 1, 0, 0, 0, 8'h72);
      #1;
      chk("R11 slot 1 cleared", disp_ready, 1);
      tick();
      idle();
      iss_allow = 1;
      #1;
      expect_issue("R11 after flush producer", 0, 8'h70);
      tick();
      #1;
      expect_issue("R11 after flush consumer", 1, 8'h71);
      tick();
      #1;
      expect_issue("R11 after flush consumer", 2, 8'h72);
      tick();
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1;
      t_reset();
      tick();
      t_ready_at_dispatch();
      t_consumer_below();
      t_fanout();
      t_same_producer();
      t_priority();
      t_full_flush();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 20000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule